// File: doc/BRIEF.md
# Dual-Direction Latched Bus Transceiver

This block sits between two buses, called port A and port B, and passes data either way through a storage latch in each direction. The data width is split into independent byte sections; by default there are two of them, so the block can serve as two separate byte-wide transceivers or as one 16-bit transceiver when the controls of both sections are tied together. Each direction of each section has three active-low controls: a chip enable, a latch enable and an output enable. The chip enable gates both loading and driving.

Tri-state pins are represented as an output value vector plus one drive-enable bit per section and port. The latches are built as clock-synchronous registers. A latch is open when its chip enable and latch enable are both low: it loads its input on every clock edge, and the output value follows the input in the same cycle with no added latency. When the latch is closed, the output value shows the stored content. Port B is driven from the A-to-B latch, and port A is driven from the B-to-A latch.

Top module: `xcv_dual_latch`

## Requirements
- R1: During synchronous reset (rst high), every drive-enable output is 0. At the first clock edge with rst high, every latch is cleared to zero, so after reset each output value reads 0 while its latch is closed.
- R2: When a direction's chip enable and latch enable are both low, its latch is open. It captures the input byte at each rising clock edge.
- R3: After the latch enable goes high with the chip enable low, the latch keeps the value captured at the last edge where it was open. Later input changes do not alter the output value.
- R4: If the chip enable goes high while the latch enable is still low, the latch stops loading and keeps its last captured value.
- R5: A port section's drive-enable is 1 exactly when that direction's chip enable and output enable are both low (outside reset). The output value then equals the latch output.
- R6: While a direction's chip enable is high, its drive-enable is 0 and its stored content does not change, whatever its latch enable and output enable are.
- R7: The B-to-A path behaves like the A-to-B path. It uses its own three controls and a separate latch, loads from port B, and drives port A.
- R8: Sections are independent. Section k's controls (bit k of each control vector) act only on data bits [8k+7:8k] and on drive bit k.
- R9: In a cycle where a latch is open, the output value equals the present input byte in that same cycle (zero cycles from input to output).
- R10: Port B of a section is driven only through the A-to-B controls, and port A only through the B-to-A controls. When only the opposite direction is enabled, the block leaves that port undriven, so it never contends with an external driver.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; latches update on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 16 | Data sampled from port A |
| b_in | input | 16 | Data sampled from port B |
| ab_ce_n | input | 2 | A-to-B chip enable per section, active low |
| ab_le_n | input | 2 | A-to-B latch enable per section, active low |
| ab_oe_n | input | 2 | A-to-B output enable per section, active low |
| ba_ce_n | input | 2 | B-to-A chip enable per section, active low |
| ba_le_n | input | 2 | B-to-A latch enable per section, active low |
| ba_oe_n | input | 2 | B-to-A output enable per section, active low |
| a_out | output | 16 | Value presented on port A |
| a_drv | output | 2 | Port A drive-enable per section |
| b_out | output | 16 | Value presented on port B |
| b_drv | output | 2 | Port B drive-enable per section |

## Verification
The bench targets the moment a latch closes. It raises the latch enable, or separately the chip enable, and then changes the input. A design that kept loading would show the new byte instead of the held one. Another common fault is letting the chip enable gate only the drive and not the loading; the bench catches this by reopening the output after the chip enable was high while fresh data sat on the input. Zero-latency transparency is checked in the same cycle the input changes, which exposes any extra register in the path. Cross-section and cross-direction checks confirm that one section's or one direction's controls never drive or load the other, which would otherwise show up as port contention.

// File: rtl/xcv_pkg.sv
package xcv_pkg;

    // Active-low control triple of one direction in one section
    typedef struct packed {
        logic ce_n;
        logic le_n;
        logic oe_n;
    } xcv_ctl_t;

    function automatic logic xcv_is_open(input xcv_ctl_t c);
        return !c.ce_n && !c.le_n;
    endfunction

    function automatic logic xcv_is_drive(input xcv_ctl_t c);
        return !c.ce_n && !c.oe_n;
    endfunction

endpackage

// File: rtl/xcv_lat_path.sv
module xcv_lat_path
    import xcv_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  xcv_ctl_t     ctl,
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o,
    output logic         drv_o
);

    typedef struct packed {
        logic [W-1:0] lat;
    } st_t;

    st_t  st_d, st_q;
    logic open_w;

    assign open_w = !rst && xcv_is_open(ctl);

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.lat = '0;
        end else if (open_w) begin
            st_d.lat = in_i;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign out_o = open_w ? in_i : st_q.lat;
    assign drv_o = !rst && xcv_is_drive(ctl);

    AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (st_q.lat == '0)) else $error("reset clear"); // R1
    AST_OPEN_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!ctl.ce_n && !ctl.le_n) |=> (st_q.lat == $past(in_i))) else $error("open load"); // R2
    AST_LE_HOLD: assert property (@(posedge clk) disable iff (rst)
        ctl.le_n |=> $stable(st_q.lat)) else $error("le hold"); // R3
    AST_CE_HOLD: assert property (@(posedge clk) disable iff (rst)
        ctl.ce_n |=> $stable(st_q.lat)) else $error("ce hold"); // R6
    AST_CE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        ctl.ce_n |-> !drv_o) else $error("ce drive"); // R6
    AST_ZERO_LAT: assert property (@(posedge clk) disable iff (rst)
        (!ctl.ce_n && !ctl.le_n) |-> (out_o == in_i)) else $error("zero latency"); // R9

endmodule

// File: rtl/xcv_section.sv
module xcv_section
    import xcv_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  xcv_ctl_t     ab_ctl,
    input  xcv_ctl_t     ba_ctl,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic         a_drv,
    output logic [W-1:0] b_out,
    output logic         b_drv
);

    // A-to-B: loads from port A, drives port B
    xcv_lat_path #(.W(W)) u_ab (
        .clk(clk), .rst(rst), .ctl(ab_ctl),
        .in_i(a_in), .out_o(b_out), .drv_o(b_drv)
    );

    // B-to-A: loads from port B, drives port A
    xcv_lat_path #(.W(W)) u_ba (
        .clk(clk), .rst(rst), .ctl(ba_ctl),
        .in_i(b_in), .out_o(a_out), .drv_o(a_drv)
    );

    AST_B_ONLY_AB: assert property (@(posedge clk) disable iff (rst)
        b_drv |-> (!ab_ctl.ce_n && !ab_ctl.oe_n)) else $error("b drive source"); // R10
    AST_A_ONLY_BA: assert property (@(posedge clk) disable iff (rst)
        a_drv |-> (!ba_ctl.ce_n && !ba_ctl.oe_n)) else $error("a drive source"); // R10

endmodule

// File: rtl/xcv_dual_latch.sv
module xcv_dual_latch
    import xcv_pkg::*;
#(
    parameter int unsigned SECT_W = 8,
    parameter int unsigned N_SECT = 2,
    localparam int unsigned BUS_W = SECT_W * N_SECT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_W-1:0]  a_in,
    input  logic [BUS_W-1:0]  b_in,
    input  logic [N_SECT-1:0] ab_ce_n,
    input  logic [N_SECT-1:0] ab_le_n,
    input  logic [N_SECT-1:0] ab_oe_n,
    input  logic [N_SECT-1:0] ba_ce_n,
    input  logic [N_SECT-1:0] ba_le_n,
    input  logic [N_SECT-1:0] ba_oe_n,
    output logic [BUS_W-1:0]  a_out,
    output logic [N_SECT-1:0] a_drv,
    output logic [BUS_W-1:0]  b_out,
    output logic [N_SECT-1:0] b_drv
);

    for (genvar k = 0; k < N_SECT; k++) begin : g_sect
        xcv_ctl_t ab_c, ba_c;
        assign ab_c = '{ce_n: ab_ce_n[k], le_n: ab_le_n[k], oe_n: ab_oe_n[k]};
        assign ba_c = '{ce_n: ba_ce_n[k], le_n: ba_le_n[k], oe_n: ba_oe_n[k]};

        xcv_section #(.W(SECT_W)) u_sect (
            .clk   (clk),
            .rst   (rst),
            .ab_ctl(ab_c),
            .ba_ctl(ba_c),
            .a_in  (a_in[k*SECT_W +: SECT_W]),
            .b_in  (b_in[k*SECT_W +: SECT_W]),
            .a_out (a_out[k*SECT_W +: SECT_W]),
            .a_drv (a_drv[k]),
            .b_out (b_out[k*SECT_W +: SECT_W]),
            .b_drv (b_drv[k])
        );
    end

    AST_RST_NO_DRIVE: assert property (@(posedge clk)
        rst |-> (a_drv == '0 && b_drv == '0)) else $error("reset drive"); // R1

endmodule

// File: tb/tb_xcv_dual_latch.sv
module tb_xcv_dual_latch;
    localparam int CLK_P = 10;

    logic        clk = 0;
    logic        rst = 1;
    logic [15:0] a_in = '0, b_in = '0;
    logic [1:0]  ab_ce_n = '1, ab_le_n = '1, ab_oe_n = '1;
    logic [1:0]  ba_ce_n = '1, ba_le_n = '1, ba_oe_n = '1;
    logic [15:0] a_out, b_out;
    logic [1:0]  a_drv, b_drv;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    xcv_dual_latch dut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
        .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
        .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // inputs change at negedge, outputs sampled 1 time unit later
    task automatic settle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1; ab_ce_n = '0; ab_oe_n = '0; ab_le_n = '0; a_in = 16'hFFFF;
        repeat (2) @(posedge clk);
        settle(); #1;
        chk("R1 drive off in reset b", {30'd0, b_drv}, 0);
        chk("R1 drive off in reset a", {30'd0, a_drv}, 0);
        ab_ce_n = '1; ab_oe_n = '1; ab_le_n = '1;
        settle(); rst = 0; #1;
        chk("R1 cleared b_out", {16'd0, b_out}, 0);
        chk("R1 cleared a_out", {16'd0, a_out}, 0);
    endtask

    task automatic t_transparent();
        settle();
        ab_ce_n[0] = 0; ab_le_n[0] = 0; ab_oe_n[0] = 0; a_in[7:0] = 8'h5A; #1;
        chk("R9 same-cycle follow", {24'd0, b_out[7:0]}, 32'h5A);
        chk("R5 drive on", {31'd0, b_drv[0]}, 1);
        settle(); a_in[7:0] = 8'hC3; #1;
        chk("R2 follow second byte", {24'd0, b_out[7:0]}, 32'hC3);
        chk("R10 port A not driven", {30'd0, a_drv}, 0);
    endtask

    task automatic t_le_hold();
        settle(); a_in[7:0] = 8'h3C;
        settle(); ab_le_n[0] = 1; a_in[7:0] = 8'hFF; #1;
        chk("R3 held after le rise", {24'd0, b_out[7:0]}, 32'h3C);
        repeat (3) @(posedge clk);
        settle(); a_in[7:0] = 8'h81; #1;
        chk("R3 still held", {24'd0, b_out[7:0]}, 32'h3C);
    endtask

    task automatic t_ce_hold();
        settle(); ab_le_n[0] = 0; a_in[7:0] = 8'h11;
        settle(); ab_ce_n[0] = 1; a_in[7:0] = 8'h22; #1;
        chk("R6 no drive with ce high", {31'd0, b_drv[0]}, 0);
        repeat (2) @(posedge clk);
        settle(); ab_oe_n[0] = 0; #1;
        chk("R6 oe low ignored while ce high", {31'd0, b_drv[0]}, 0);
        settle(); ab_le_n[0] = 1; ab_ce_n[0] = 0; #1;
        chk("R4 kept value when ce rose", {24'd0, b_out[7:0]}, 32'h11);
        chk("R5 drive on again", {31'd0, b_drv[0]}, 1);
    endtask

    task automatic t_oe();
        settle(); ab_oe_n[0] = 1; #1;
        chk("R5 oe high no drive", {31'd0, b_drv[0]}, 0);
        chk("R5 value shows latch", {24'd0, b_out[7:0]}, 32'h11);
        settle(); ab_oe_n[0] = 0; #1;
        chk("R5 oe low drives latch", {23'd0, b_drv[0], b_out[7:0]}, 32'h111);
        settle(); ab_ce_n[0] = 1; ab_oe_n[0] = 1;
    endtask

    task automatic t_ba();
        settle(); b_in[7:0] = 8'hA7; ba_ce_n[0] = 0; ba_le_n[0] = 0; ba_oe_n[0] = 0; #1;
        chk("R7 B-to-A follows", {24'd0, a_out[7:0]}, 32'hA7);
        chk("R10 no contention on port B", {31'd0, b_drv[0]}, 0);
        settle(); ba_le_n[0] = 1; b_in[7:0] = 8'h00; #1;
        chk("R7 B-to-A holds", {23'd0, a_drv[0], a_out[7:0]}, 32'h1A7);
        chk("R10 A-to-B latch untouched", {24'd0, b_out[7:0]}, 32'h11);
        settle(); ba_ce_n[0] = 1; ba_oe_n[0] = 1;
    endtask

    task automatic t_sections();
        settle(); ab_ce_n[1] = 0; ab_le_n[1] = 0; ab_oe_n[1] = 0; a_in = 16'h7766;
        settle(); ab_le_n[1] = 1; a_in = 16'h0000; #1;
        chk("R8 section 1 held", {24'd0, b_out[15:8]}, 32'h77);
        chk("R8 section 0 untouched", {24'd0, b_out[7:0]}, 32'h11);
        chk("R8 drive bits", {30'd0, b_drv}, 32'h2);
        chk("R8 port A section 1 not loaded", {24'd0, a_out[15:8]}, 0);
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_transparent();
        t_le_hold();
        t_ce_hold();
        t_oe();
        t_ba();
        t_sections();
        repeat (2) @(posedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule